// File: doc/BRIEF.md
# Master frame sync generator

This block supplies the timing for a basic-access data port when that port drives its own clocks. It runs from a fast system clock and divides it down into three things. The first is a bit clock enable. The second is a pair of 8 kHz frame pulses: the first marks the opening 8-bit slot for both directions, and the second marks the slot that follows. The third is a free-running 16 kHz clock for a separate D channel port. Moving data and detecting sync in slave mode are left to other blocks.

The frame pulses take one of two shapes. In the non-delayed shape, each pulse stays high for its whole 8-bit slot. In the delayed shape, each pulse is one bit wide and comes one bit period before its slot. The selected frame layout can override the requested shape: the split layout always uses the delayed shape, and the GCI-like layout always uses the non-delayed shape. The shape and the layout are captured when the generator is enabled. While the generator is disabled, every output is held low. On enable, the frame begins again at bit zero.

Top module: `fsync_master_gen`

## Requirements
- R1: While `rst_n` or `enable` is low, all five outputs are low. After `enable` is sampled low, all outputs are low from the following clock edge onward.
- R2: While enabled, `bit_tick` is a one-cycle pulse that occurs every CLK_PER_BIT system clocks. The first pulse comes in the cycle that follows the edge at which `enable` is first sampled high.
- R3: A frame lasts BITS_PER_FRAME bit periods and repeats without a gap. On every enable, the frame restarts at bit 0. Bit 0 is the bit that begins with the first `bit_tick`.
- R4: In the non-delayed shape, `fs_first` is high during bits 0 to 7 of every frame and `fs_second` is high during bits 8 to 15.
- R5: In the delayed shape, `fs_first` is high only during bit BITS_PER_FRAME-1 and `fs_second` is high only during bit 7. Each is a pulse one bit wide that comes just before its slot.
- R6: The `layout_sel` codes are 0 = sequential 18-bit layout, 1 = split layout, 2 = free slot layout and 3 = GCI-like layout. When `delayed_sel` = 1, the delayed shape is requested. Code 1 forces the delayed shape and code 3 forces the non-delayed shape, whatever `delayed_sel` holds. Codes 0 and 2 follow `delayed_sel`.
- R7: `dclk` is a square wave with a period of CLK_PER_BIT*BITS_PER_FRAME/2 system clocks, which is two per frame. It is low for the first half of each period, counted from enable. `dclk_tick` is high for exactly the one cycle in which `dclk` goes high.
- R8: `layout_sel` and `delayed_sel` are captured at the edge where `enable` is first sampled high. Changes to them while the block stays enabled have no effect on the outputs.
- R9: `fs_first` and `fs_second` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator when high |
| delayed_sel | input | 1 | Requests the delayed pulse shape |
| layout_sel | input | 2 | Frame layout code |
| bit_tick | output | 1 | One-cycle enable at the start of each bit |
| fs_first | output | 1 | Frame pulse for the first slot |
| fs_second | output | 1 | Frame pulse for the second slot |
| dclk | output | 1 | 16 kHz D channel clock level |
| dclk_tick | output | 1 | One-cycle enable on each rising transition of `dclk` |

## Verification
The assertions assume that `enable` is a synchronous level and that CLK_PER_BIT is at least 2, so two bit ticks can never fall in adjacent cycles. The assertions that check pulse edges apply only after `enable` has been high for two consecutive samples, since the outputs jump into place at the start of a run. The stimulus changes `enable`, `layout_sel` and `delayed_sel` only on falling clock edges. Each run lasts a whole number of cycles followed by an idle gap. The bench scrambles the configuration inputs during runs to exercise R8.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   typedef enum logic [1:0] {
      LAY_SEQ   = 2'd0,
      LAY_SPLIT = 2'd1,
      LAY_SLOT  = 2'd2,
      LAY_GCI   = 2'd3
   } layout_e;

   // Resolve the requested pulse shape against what the layout permits.
   function automatic logic eff_delayed(layout_e lay, logic req);
      case (lay)
         LAY_SPLIT: return 1'b1;
         LAY_GCI:   return 1'b0;
         default:   return req;
      endcase
   endfunction

endpackage

// File: rtl/fsg_bit_timer.sv
module fsg_bit_timer #(
   parameter int CLK_PER_BIT    = 4,
   parameter int BITS_PER_FRAME = 32,
   localparam int CW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1,
   localparam int BW = $clog2(BITS_PER_FRAME)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic          tick,
   output logic [BW-1:0] bit_idx
);

   localparam logic [CW-1:0] CLK_LAST = CW'(CLK_PER_BIT - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_FRAME - 1);

   logic [CW-1:0] clk_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_cnt <= '0;
         bit_idx <= '0;
      end else if (!run) begin
         clk_cnt <= '0;
         bit_idx <= '0;
      end else if (clk_cnt == CLK_LAST) begin
         clk_cnt <= '0;
         bit_idx <= (bit_idx == BIT_LAST) ? '0 : bit_idx + 1'b1;
      end else begin
         clk_cnt <= clk_cnt + 1'b1;
      end
   end

   assign tick = run && (clk_cnt == '0);

endmodule

// File: rtl/fsg_sync_shaper.sv
module fsg_sync_shaper #(
   parameter int BITS_PER_FRAME = 32,
   parameter int SLOT_BITS      = 8,
   parameter int NPULSE         = 2,
   localparam int BW = $clog2(BITS_PER_FRAME)
) (
   input  logic              run,
   input  logic              delayed,
   input  logic [BW-1:0]     bit_idx,
   output logic [NPULSE-1:0] fs
);

   for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
      localparam int START = i * SLOT_BITS;
      localparam int PRE   = (START + BITS_PER_FRAME - 1) % BITS_PER_FRAME;
      logic [BW-1:0] rel;
      logic          in_slot;
      logic          at_pre;
      assign rel     = bit_idx - BW'(START);
      assign in_slot = rel < BW'(SLOT_BITS);
      assign at_pre  = bit_idx == BW'(PRE);
      assign fs[i]   = run && (delayed ? at_pre : in_slot);
   end

endmodule

// File: rtl/fsg_dclk_div.sv
module fsg_dclk_div #(
   parameter int DIV = 64,
   localparam int DW   = $clog2(DIV),
   localparam int HALF = DIV / 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic dclk,
   output logic dclk_tick
);

   logic [DW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == DW'(DIV - 1))
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign dclk      = run && (cnt >= DW'(HALF));
   assign dclk_tick = run && (cnt == DW'(HALF));

endmodule

// File: rtl/fsync_master_gen.sv
module fsync_master_gen #(
   parameter int CLK_PER_BIT    = 4,
   parameter int BITS_PER_FRAME = 32,
   parameter int SLOT_BITS      = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       delayed_sel,
   input  logic [1:0] layout_sel,
   output logic       bit_tick,
   output logic       fs_first,
   output logic       fs_second,
   output logic       dclk,
   output logic       dclk_tick
);
   import fsg_pkg::*;

   localparam int BW       = $clog2(BITS_PER_FRAME);
   localparam int DCLK_DIV = CLK_PER_BIT * BITS_PER_FRAME / 2;
   localparam int MIN_BITS = 26;

   if (CLK_PER_BIT < 2) begin : g_bad_cpb
      $error("CLK_PER_BIT must be at least 2");
   end
   if (BITS_PER_FRAME < MIN_BITS) begin : g_bad_bpf
      $error("BITS_PER_FRAME too short for the longest layout");
   end
   if ((CLK_PER_BIT * BITS_PER_FRAME) % 4 != 0) begin : g_bad_div
      $error("frame length in clocks must split into two even D clock periods");
   end
   if (2 * SLOT_BITS > BITS_PER_FRAME) begin : g_bad_slot
      $error("two slots must fit in a frame");
   end

   logic    run_q;
   layout_e lay_q;
   logic    dly_req_q;
   logic    dly_eff;
   logic [BW-1:0] bit_idx;
   logic [1:0]    fs_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         lay_q     <= LAY_SEQ;
         dly_req_q <= 1'b0;
      end else begin
         run_q <= enable;
         if (enable && !run_q) begin
            lay_q     <= layout_e'(layout_sel);
            dly_req_q <= delayed_sel;
         end
      end
   end

   assign dly_eff = eff_delayed(lay_q, dly_req_q);

   fsg_bit_timer #(
      .CLK_PER_BIT   (CLK_PER_BIT),
      .BITS_PER_FRAME(BITS_PER_FRAME)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .tick   (bit_tick),
      .bit_idx(bit_idx)
   );

   fsg_sync_shaper #(
      .BITS_PER_FRAME(BITS_PER_FRAME),
      .SLOT_BITS     (SLOT_BITS),
      .NPULSE        (2)
   ) u_shaper (
      .run    (run_q),
      .delayed(dly_eff),
      .bit_idx(bit_idx),
      .fs     (fs_vec)
   );

   assign fs_first  = fs_vec[0];
   assign fs_second = fs_vec[1];

   fsg_dclk_div #(
      .DIV(DCLK_DIV)
   ) u_dclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .dclk     (dclk),
      .dclk_tick(dclk_tick)
   );

endmodule

// File: rtl/fsync_master_gen_chk.sv
module fsync_master_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic bit_tick,
   input logic fs_first,
   input logic fs_second,
   input logic dclk,
   input logic dclk_tick
);

   logic en_d1, en_d2;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d1 <= 1'b0;
         en_d2 <= 1'b0;
      end else begin
         en_d1 <= enable;
         en_d2 <= en_d1;
      end
   end

   p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !(bit_tick || fs_first || fs_second || dclk || dclk_tick));

   p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !bit_tick);

   p_fs_first_on_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_d1 && en_d2 && !$stable(fs_first)) |-> bit_tick);

   p_fs_second_on_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_d1 && en_d2 && !$stable(fs_second)) |-> bit_tick);

   p_dclk_rise_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_d1 && en_d2 && $rose(dclk)) |-> dclk_tick);

   p_fs_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(fs_first && fs_second));

endmodule

bind fsync_master_gen fsync_master_gen_chk u_chk (.*);

// File: tb/fsync_master_gen_tb.sv
`timescale 1ns/1ps
module fsync_master_gen_tb;

   localparam int CPB  = 4;
   localparam int BPF  = 32;
   localparam int DPER = CPB * BPF / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       delayed_sel = 1'b0;
   logic [1:0] layout_sel = 2'd0;
   logic bit_tick, fs_first, fs_second, dclk, dclk_tick;

   int vecs = 0;
   int errs = 0;

   always #2.5 clk = ~clk;

   fsync_master_gen #(.CLK_PER_BIT(CPB), .BITS_PER_FRAME(BPF)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .delayed_sel(delayed_sel),
      .layout_sel(layout_sel), .bit_tick(bit_tick), .fs_first(fs_first),
      .fs_second(fs_second), .dclk(dclk), .dclk_tick(dclk_tick));

   function automatic bit eff_dly(int lay, bit req);
      if (lay == 1) return 1'b1;
      if (lay == 3) return 1'b0;
      return req;
   endfunction

   function automatic bit exp_fs(int n, int idx, bit dly);
      int b  = (n / CPB) % BPF;
      int st = idx * 8;
      if (dly) return b == (st + BPF - 1) % BPF;
      return (b >= st) && (b < st + 8);
   endfunction

   task automatic chk(string tag, logic got, logic exp, int n);
      vecs++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s at n=%0d: got %b expected %b", tag, n, got, exp);
      end
   endtask

   task automatic chk_idle(string tag);
      chk({tag, " bit_tick"},  bit_tick,  1'b0, -1);
      chk({tag, " fs_first"},  fs_first,  1'b0, -1);
      chk({tag, " fs_second"}, fs_second, 1'b0, -1);
      chk({tag, " dclk"},      dclk,      1'b0, -1);
      chk({tag, " dclk_tick"}, dclk_tick, 1'b0, -1);
   endtask

   task automatic run_one(int ncyc, int lay, bit dly, bit scramble);
      bit    d;
      string ftag;
      @(negedge clk);
      layout_sel  = 2'(lay);
      delayed_sel = dly;
      enable      = 1'b1;
      d = eff_dly(lay, dly);
      chk_idle("R1 before first edge");
      ftag = d ? "R5" : "R4";
      if (lay == 1 || lay == 3) ftag = {ftag, "/R6"};
      if (scramble) ftag = {ftag, "/R8"};
      for (int n = 0; n < ncyc; n++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R2 bit_tick", bit_tick, (n % CPB) == 0, n);
         chk({ftag, " R3 fs_first"}, fs_first, exp_fs(n, 0, d), n);
         chk({ftag, " fs_second"}, fs_second, exp_fs(n, 1, d), n);
         chk("R7 dclk", dclk, (n % DPER) >= DPER / 2, n);
         chk("R7 dclk_tick", dclk_tick, (n % DPER) == DPER / 2, n);
         chk("R9 exclusive", fs_first && fs_second, 1'b0, n);
         if (scramble) begin
            layout_sel  = 2'($urandom_range(0, 3));
            delayed_sel = 1'($urandom_range(0, 1));
         end
      end
      enable = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk_idle("R1 after disable");
   endtask

   initial begin
      #1_000_000;
      errs++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      enable = 1'b1;
      chk_idle("R1 in reset");
      enable = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_idle("R1 idle");
      // directed: every layout with both requests, two frames each
      for (int lay = 0; lay < 4; lay++)
         for (int r = 0; r < 2; r++)
            run_one(2 * CPB * BPF, lay, 1'(r), 1'b0);
      // short run: restart mid-frame realigns to bit 0 (R3)
      run_one(37, 0, 1'b0, 1'b0);
      run_one(CPB * BPF + 5, 2, 1'b1, 1'b0);
      // random runs, some with config scrambled while enabled
      for (int k = 0; k < 30; k++) begin
         run_one($urandom_range(20, 3 * CPB * BPF), $urandom_range(0, 3),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         repeat ($urandom_range(0, 5)) @(negedge clk);
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule